// File: doc/BRIEF.md
# Countdown Timer and Interrupt Generator

This block is an 8-bit down-counter with a programmable reload value. It advances on enable ticks from an external prescaler. One of four tick rates is chosen as the counting source: 4096 Hz, 64 Hz, 1 Hz or one tick per minute. Each time a full period of n source ticks has elapsed, the counter reloads itself and raises a timer flag. An alarm flag is raised by a one-cycle pulse from a separate alarm comparator.

The interrupt output drives an active-low open-drain line and has two modes:

- **Level mode:** the line follows the enabled flags.
- **Pulse mode:** the timer part of the interrupt becomes a short pulse at every period end. The pulse is timed with an 8192 Hz tick, and its width depends on the source rate and on whether the reload value is one.

Flags are cleared through a status write that is ANDed with the stored flags. Software can therefore clear one flag without losing another flag that is set at the same time. A bus decoder outside this block drives the three write ports and reads back the control, status and count bytes.

Top module: `cdt_irq_unit`

## Requirements
- R1: After reset the control byte reads 0x03 (timer off, one-per-minute source), the status byte reads 0x00, the count reads 0 and `irq_drive` is 0.
- R2: Control bit 7 enables counting. Control bits [1:0] pick the source: 00 = 4096 Hz, 01 = 64 Hz, 10 = 1 Hz, 11 = per minute. With the timer off, or on ticks of an unselected rate, the count does not change.
- R3: A count write sets both the reload value and the current count. Each selected tick then lowers the readable count by one.
- R4: A reload value of 0 stops the timer: ticks neither change the count nor set the timer flag.
- R5: On the n-th selected tick of a period, the timer flag (status bit 2) is set and the count reads n again on the next cycle.
- R6: A status write ANDs bit 3 (alarm flag) and bit 2 (timer flag) with their stored values. Bits 4 (pulse mode), 1 (alarm enable) and 0 (timer enable) take the written value.
- R7: A pulse on `alarm_set` sets the alarm flag. Both flags hold until a status write clears them.
- R8: In level mode, `irq_drive` = (timer flag AND timer enable) OR (alarm flag AND alarm enable). With both enables at 0, `irq_drive` stays 0 whatever the flags are.
- R9: In pulse mode with the timer enable set, `irq_drive` rises on the same cycle as the timer flag. It then stays high for this many 8192 Hz ticks:
  - 4096 Hz source: 1 tick when n = 1, 2 ticks otherwise.
  - 64 Hz source: 64 ticks when n = 1, 128 ticks otherwise.
  - 1 Hz and per-minute sources: 128 ticks.
- R10: A period end that falls during a running pulse restarts the pulse width from its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_8k | input | 1 | 8192 Hz enable tick used to time pulse widths |
| tick_4k | input | 1 | 4096 Hz source tick |
| tick_64 | input | 1 | 64 Hz source tick |
| tick_1s | input | 1 | 1 Hz source tick |
| tick_1m | input | 1 | One-per-minute source tick |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control write data: bit 7 enable, bits [1:0] source |
| cnt_wr | input | 1 | Write strobe for the reload value |
| cnt_wdata | input | 8 | Reload value n |
| cs_wr | input | 1 | Write strobe for the status byte |
| cs_wdata | input | 8 | Status write data: bit 4 pulse mode, bit 3 alarm flag, bit 2 timer flag, bit 1 alarm enable, bit 0 timer enable |
| alarm_set | input | 1 | One-cycle pulse that sets the alarm flag |
| irq_drive | output | 1 | 1 = pull the open-drain interrupt line low |
| ctl_rdata | output | 8 | Control byte readback |
| cs_rdata | output | 8 | Status byte readback |
| cnt_rdata | output | 8 | Current countdown value |

## Verification
The hardest situation to reach from the ports is a second period end that lands while an interrupt pulse is still running. A width measured alone cannot tell a restarted pulse from one that merely finishes. The stimulus uses the 64 Hz source with n = 1, so every source tick ends a period. It starts a 64-tick pulse and lets ten 8192 Hz ticks pass. It then issues another source tick and counts the remaining high ticks: the count is 64 with a restart and 54 without one. The per-rate widths are walked from a vector table, and each one is measured by stepping the fast tick until the line drops.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    SRC_4K = 2'b00,
    SRC_64 = 2'b01,
    SRC_1S = 2'b10,
    SRC_1M = 2'b11
  } src_e;

  localparam int unsigned FAST_HZ = 8192;
  localparam int unsigned PW_W    = 8;

  // status byte bit positions (decoded by the bus side)
  localparam int unsigned ST_TIE = 0;
  localparam int unsigned ST_AIE = 1;
  localparam int unsigned ST_TF  = 2;
  localparam int unsigned ST_AF  = 3;
  localparam int unsigned ST_PM  = 4;
  localparam int unsigned CT_EN  = 7;

  // pulse length in fast ticks
  function automatic logic [PW_W-1:0] pulse_len(src_e s, logic single);
    case (s)
      SRC_4K:  return single ? PW_W'(FAST_HZ / 8192) : PW_W'(FAST_HZ / 4096);
      SRC_64:  return single ? PW_W'(FAST_HZ / 128)  : PW_W'(FAST_HZ / 64);
      default: return PW_W'(FAST_HZ / 64);
    endcase
  endfunction

endpackage

// File: rtl/cdt_src_mux.sv
module cdt_src_mux
  import cdt_pkg::*;
(
  input  src_e       sel,
  input  logic [3:0] src_ticks,
  output logic       tick
);
  always_comb tick = src_ticks[sel];
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cur,
  output logic [W-1:0] reload,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  logic step;
  assign step = run && tick && !load && (reload != '0);
  assign wrap = step && (cur <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      reload <= '0;
    end else if (load) begin
      cur    <= load_val;
      reload <= load_val;
    end else if (wrap) begin
      cur    <= reload;
    end else if (step) begin
      cur    <= cur - ONE;
    end
  end
endmodule

// File: rtl/cdt_pulse.sv
module cdt_pulse #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] len,
  input  logic          tick_fast,
  output logic          active
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                            left_q <= '0;
    else if (start)                     left_q <= len;
    else if (tick_fast && left_q != '0) left_q <= left_q - PW'(1);
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/cdt_irq_unit.sv
module cdt_irq_unit
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_8k,
  input  logic             tick_4k,
  input  logic             tick_64,
  input  logic             tick_1s,
  input  logic             tick_1m,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cs_wr,
  input  logic [7:0]       cs_wdata,
  input  logic             alarm_set,
  output logic             irq_drive,
  output logic [7:0]       ctl_rdata,
  output logic [7:0]       cs_rdata,
  output logic [CNT_W-1:0] cnt_rdata
);
  logic             en_q;
  src_e             sel_q;
  logic             pm_q, af_q, tf_q, aie_q, tie_q;
  logic             src_tick, tmr_wrap, pulse_on;
  logic [CNT_W-1:0] reload_q;

  cdt_src_mux u_mux (
    .sel       (sel_q),
    .src_ticks ({tick_1m, tick_1s, tick_64, tick_4k}),
    .tick      (src_tick)
  );

  cdt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_wr),
    .load_val (cnt_wdata),
    .run      (en_q),
    .tick     (src_tick),
    .cur      (cnt_rdata),
    .reload   (reload_q),
    .wrap     (tmr_wrap)
  );

  cdt_pulse #(.PW(PW_W)) u_pls (
    .clk       (clk),
    .rst       (rst),
    .start     (tmr_wrap),
    .len       (pulse_len(sel_q, reload_q == CNT_W'(1))),
    .tick_fast (tick_8k),
    .active    (pulse_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= SRC_1M;
    end else if (ctl_wr) begin
      en_q  <= ctl_wdata[CT_EN];
      sel_q <= src_e'(ctl_wdata[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q  <= 1'b0;
      af_q  <= 1'b0;
      tf_q  <= 1'b0;
      aie_q <= 1'b0;
      tie_q <= 1'b0;
    end else begin
      // set events win over a clearing write on the same cycle
      tf_q <= (tf_q & (~cs_wr | cs_wdata[ST_TF])) | tmr_wrap;
      af_q <= (af_q & (~cs_wr | cs_wdata[ST_AF])) | alarm_set;
      if (cs_wr) begin
        pm_q  <= cs_wdata[ST_PM];
        aie_q <= cs_wdata[ST_AIE];
        tie_q <= cs_wdata[ST_TIE];
      end
    end
  end

  always_comb begin
    irq_drive = (af_q & aie_q) | (tie_q & (pm_q ? pulse_on : tf_q));
    ctl_rdata = {en_q, 5'b0, sel_q};
    cs_rdata  = {3'b0, pm_q, af_q, tf_q, aie_q, tie_q};
  end
endmodule

// File: rtl/cdt_chk.sv
module cdt_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_wr,
  input logic             cs_wr,
  input logic [7:0]       cs_wdata,
  input logic             irq_drive,
  input logic [7:0]       ctl_rdata,
  input logic [7:0]       cs_rdata,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             wrap,
  input logic [CNT_W-1:0] reload
);
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rdata[7] && !cnt_wr) |=> $stable(cnt_rdata));

  a_r5_reload_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (wrap && !cnt_wr) |=> (cnt_rdata == $past(reload)));

  a_r6_and_clear_tf: assert property (@(posedge clk) disable iff (rst)
    (cs_wr && !cs_wdata[2] && !wrap) |=> !cs_rdata[2]);

  a_r7_af_holds: assert property (@(posedge clk) disable iff (rst)
    (cs_rdata[3] && !cs_wr) |=> cs_rdata[3]);

  a_r8_released: assert property (@(posedge clk) disable iff (rst)
    (!cs_rdata[0] && !cs_rdata[1]) |-> !irq_drive);

  a_r9_pulse_with_tf: assert property (@(posedge clk) disable iff (rst)
    (wrap && cs_rdata[4] && cs_rdata[0] && !cs_wr) |=> (irq_drive && cs_rdata[2]));
endmodule

bind cdt_irq_unit cdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_wr    (cnt_wr),
  .cs_wr     (cs_wr),
  .cs_wdata  (cs_wdata),
  .irq_drive (irq_drive),
  .ctl_rdata (ctl_rdata),
  .cs_rdata  (cs_rdata),
  .cnt_rdata (cnt_rdata),
  .wrap      (tmr_wrap),
  .reload    (reload_q)
);

// File: tb/tb_cdt_irq_unit.sv
module tb_cdt_irq_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ticks = '0;  // 0:8k 1:4k 2:64 3:1s 4:1m
  logic       ctl_wr = 0, cnt_wr = 0, cs_wr = 0, alarm_set = 0;
  logic [7:0] ctl_wdata = 0, cnt_wdata = 0, cs_wdata = 0;
  logic       irq_drive;
  logic [7:0] ctl_rdata, cs_rdata, cnt_rdata;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  cdt_irq_unit dut (
    .clk(clk), .rst(rst),
    .tick_8k(ticks[0]), .tick_4k(ticks[1]), .tick_64(ticks[2]),
    .tick_1s(ticks[3]), .tick_1m(ticks[4]),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cs_wr(cs_wr), .cs_wdata(cs_wdata),
    .alarm_set(alarm_set), .irq_drive(irq_drive),
    .ctl_rdata(ctl_rdata), .cs_rdata(cs_rdata), .cnt_rdata(cnt_rdata)
  );

  // {src sel, n, expected width in 8192 Hz ticks}
  localparam logic [23:0] VEC [6] = '{
    {8'd0, 8'd1, 8'd1},   {8'd0, 8'd5, 8'd2},
    {8'd1, 8'd1, 8'd64},  {8'd1, 8'd3, 8'd128},
    {8'd2, 8'd1, 8'd128}, {8'd3, 8'd2, 8'd128}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int idx);
    @(negedge clk) ticks[idx] = 1'b1;
    @(negedge clk) ticks[idx] = 1'b0;
  endtask

  task automatic w_ctl(logic [7:0] d);
    @(negedge clk) begin ctl_wr = 1; ctl_wdata = d; end
    @(negedge clk) ctl_wr = 0;
  endtask

  task automatic w_cnt(logic [7:0] d);
    @(negedge clk) begin cnt_wr = 1; cnt_wdata = d; end
    @(negedge clk) cnt_wr = 0;
  endtask

  task automatic w_cs(logic [7:0] d);
    @(negedge clk) begin cs_wr = 1; cs_wdata = d; end
    @(negedge clk) cs_wr = 0;
  endtask

  task automatic pulse_alarm();
    @(negedge clk) alarm_set = 1;
    @(negedge clk) alarm_set = 0;
  endtask

  function automatic int measure_dummy(); return 0; endfunction

  task automatic measure(output int k);
    k = 0;
    while (irq_drive && k < 300) begin
      tick(0);
      k++;
    end
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ctl", ctl_rdata, 8'h03);
    check("R1 status", cs_rdata, 8'h00);
    check("R1 count", cnt_rdata, 0);
    check("R1 irq", irq_drive, 0);

    // pulse widths per source and reload value
    for (int v = 0; v < 6; v++) begin
      int sel = int'(VEC[v][17:16]);
      int n   = int'(VEC[v][15:8]);
      int pw  = int'(VEC[v][7:0]);
      w_ctl(8'h80 | 8'(sel));
      w_cnt(8'(n));
      w_cs(8'h11);
      for (int k = 1; k < n; k++) tick(sel + 1);
      check("R3 count before end", cnt_rdata, 1);
      check("R9 no pulse before end", irq_drive, 0);
      tick(sel + 1);
      check("R5 timer flag", cs_rdata[2], 1);
      check("R5 reload", cnt_rdata, n);
      check("R9 pulse with flag", irq_drive, 1);
      measure(w);
      check("R9 pulse width", w, pw);
    end

    // restart during a pulse
    w_ctl(8'h81);
    w_cnt(8'd1);
    w_cs(8'h11);
    tick(2);
    for (int k = 0; k < 10; k++) tick(0);
    check("R10 still high", irq_drive, 1);
    tick(2);
    measure(w);
    check("R10 restarted width", w, 64);

    // readback and source selection
    w_cs(8'h00);
    w_ctl(8'h80);
    w_cnt(8'd10);
    tick(1); tick(1); tick(1);
    check("R3 readback", cnt_rdata, 7);
    w_ctl(8'h00);
    w_cnt(8'd5);
    tick(1); tick(1); tick(1);
    check("R2 timer off holds", cnt_rdata, 5);
    w_ctl(8'h81);
    tick(1); tick(3); tick(4); tick(0);
    check("R2 unselected ticks ignored", cnt_rdata, 5);
    tick(2);
    check("R2 selected tick counts", cnt_rdata, 4);

    // reload of zero stops the timer
    w_ctl(8'h80);
    w_cnt(8'd0);
    for (int k = 0; k < 5; k++) tick(1);
    check("R4 count stays 0", cnt_rdata, 0);
    check("R4 no flag", cs_rdata[2], 0);

    // level mode and flag writes
    w_cnt(8'd2);
    w_cs(8'h01);
    tick(1); tick(1);
    check("R8 level irq on timer flag", irq_drive, 1);
    w_cs(8'h04);
    check("R8 timer enable off releases", irq_drive, 0);
    check("R6 write 1 keeps timer flag", cs_rdata[2], 1);
    pulse_alarm();
    repeat (5) @(negedge clk);
    check("R7 alarm flag held", cs_rdata[3], 1);
    check("R8 both enables off", irq_drive, 0);
    w_cs(8'h0E);
    check("R8 alarm drives irq", irq_drive, 1);
    w_cs(8'h06);
    check("R6 AND write clears only AF", cs_rdata, 8'h06);
    check("R8 irq after AF cleared", irq_drive, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule